// File: doc/BRIEF.md
# Multi-Precision Vector MAC Unit

This block is a wide multiply-accumulate engine for quantized neural network layers. Each accepted beat brings a 1024-bit activation vector and a 1024-bit weight vector. Both vectors are split into 32 entries of 32 bits, one entry per output channel. Every channel keeps its own 32-bit accumulator. On each beat, the channel adds the dot product of its activation entry and its weight entry.

The same 32-bit entry is read in one of three ways, chosen by the mode input:

- four signed 8-bit values,
- thirty-two binary values,
- sixteen ternary values.

So the number of input channels folded into one accumulator per beat is the entry width divided by the operand width.

A broadcast control takes activation entry 0 and uses it against every weight entry. This gives the scalar-vector form of the operation. A clear control empties the accumulators, or makes the next beat load its sum in place of adding it.

The input side is a valid/ready stream. The unit never applies back-pressure: `in_ready` is held high, and a beat is taken on every rising edge where `in_valid` is high. The result side has no back-pressure either. `acc_valid` pulses for one cycle after each taken beat, with `acc_vec` already updated. A consumer that wants a beat's result must sample it in that cycle, because the next beat may change the accumulators.

Top module: `mvmac_top`

## Requirements
- R1: While `rst_n` is low and after it is released, every accumulator reads zero and `acc_valid` is low.
- R2: `in_ready` is always high. A beat is taken on every rising edge with `in_valid` high. `acc_valid` is high in exactly the cycle after each taken beat, and `acc_vec` then already includes that beat.
- R3: Mode 2'b00 (int8): each 32-bit entry holds four signed bytes, byte i at bits [8i+7:8i]. The channel adds the sum of the four byte-by-byte signed products.
- R4: Mode 2'b01 (binary): bit value 1 means +1 and 0 means -1. The channel adds 2 × (number of bit positions where activation and weight agree) − 32.
- R5: Mode 2'b10 (ternary): each entry holds sixteen trits, trit j at bits [2j+1:2j]. The codes are 2'b01 = +1, 2'b11 = −1, and 2'b00 or 2'b10 = 0. The channel adds the sum of the sixteen trit products.
- R6: With `in_bcast` high, activation entry 0 (`in_act[31:0]`) is used for every channel. The upper activation bits then have no effect.
- R7: With `in_bcast` low, channel k pairs `in_act[32k+31:32k]` with `in_wgt[32k+31:32k]`. Its accumulator appears at `acc_vec[32k+31:32k]`.
- R8: `acc_clr` high without a beat sets every accumulator to zero on the next edge.
- R9: `acc_clr` high together with a beat loads each accumulator with that beat's dot product.
- R10: Accumulators wrap in 32-bit two's complement on overflow.
- R11: Mode 2'b11 is reserved. A beat in that mode adds nothing to any accumulator.
- R12: With neither a beat nor `acc_clr`, every accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Always high; the unit accepts every beat |
| in_mode | input | 2 | Operand precision: 00 int8, 01 binary, 10 ternary, 11 reserved |
| in_bcast | input | 1 | Use activation entry 0 for all channels |
| acc_clr | input | 1 | Zero the accumulators, or load instead of add on a beat |
| in_act | input | 1024 | Activation vector, 32 entries of 32 bits |
| in_wgt | input | 1024 | Weight vector, one 32-bit entry per output channel |
| acc_valid | output | 1 | One-cycle pulse after each taken beat |
| acc_vec | output | 1024 | 32 accumulators of 32 bits, channel k at bits [32k+31:32k] |

## Verification
The hardest condition to reach from the ports is accumulator wrap-around. A single beat adds at most 65536 per channel, so crossing the signed 32-bit limit takes tens of thousands of beats. The stimulus first loads 65536 into every channel using a clear-qualified int8 beat of all −128 bytes. It then streams 32767 more such beats back to back. The final value must read 0x80000000. Broadcast is shown to ignore the upper activation entries by filling them with random data the reference model never uses. Ternary beats mix all four trit codes, including the second zero code.

// File: rtl/mvmac_pkg.sv
package mvmac_pkg;

  typedef enum logic [1:0] {
    MD_INT8 = 2'd0,
    MD_BIN  = 2'd1,
    MD_TER  = 2'd2,
    MD_RSV  = 2'd3
  } mac_mode_e;

endpackage

// File: rtl/mvmac_route.sv
module mvmac_route #(
  parameter int NUM_CH = 32,
  parameter int LANE_W = 32,
  localparam int VEC_W = NUM_CH * LANE_W
) (
  input  logic             bcast,
  input  logic [VEC_W-1:0] act_vec,
  output logic [VEC_W-1:0] act_sel
);

  // In scalar-vector form every channel sees entry 0 of the activations.
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign act_sel[k*LANE_W +: LANE_W] = bcast ? act_vec[LANE_W-1:0]
                                               : act_vec[k*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/mvmac_lane_dot.sv
module mvmac_lane_dot
  import mvmac_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int ACC_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  mac_mode_e               mode,
  input  logic [LANE_W-1:0]       a,
  input  logic [LANE_W-1:0]       w,
  output logic signed [ACC_W-1:0] dot
);

  localparam int N8  = LANE_W / 8;
  localparam int NTR = LANE_W / 2;
  localparam int PCW = $clog2(LANE_W + 1);
  localparam int TCW = $clog2(NTR + 1);
  localparam logic signed [ACC_W-1:0] BIN_LIM = ACC_W'(LANE_W);
  localparam logic signed [ACC_W-1:0] TER_LIM = ACC_W'(NTR);
  localparam logic signed [ACC_W-1:0] I8_LIM  = ACC_W'(N8 * 16384);

  // int8: one signed multiplier per byte
  logic signed [15:0]      prod [N8];
  logic signed [ACC_W-1:0] sum8;

  for (genvar i = 0; i < N8; i++) begin : g_byte
    assign prod[i] = $signed(a[8*i +: 8]) * $signed(w[8*i +: 8]);
  end

  always_comb begin
    sum8 = '0;
    for (int i = 0; i < N8; i++) begin
      sum8 = sum8 + {{(ACC_W-16){prod[i][15]}}, prod[i]};
    end
  end

  // binary: agreement count mapped back to a signed sum
  logic [LANE_W-1:0]       agree;
  logic [PCW-1:0]          pcnt;
  logic signed [ACC_W-1:0] sumb;

  assign agree = ~(a ^ w);

  always_comb begin
    pcnt = '0;
    for (int i = 0; i < LANE_W; i++) begin
      pcnt = pcnt + PCW'(agree[i]);
    end
    sumb = ACC_W'({pcnt, 1'b0}) - BIN_LIM;
  end

  // ternary: low bit of a trit marks non-zero, high bit marks negative
  logic [NTR-1:0]          t_live;
  logic [NTR-1:0]          t_neg;
  logic [TCW-1:0]          npos;
  logic [TCW-1:0]          nneg;
  logic signed [ACC_W-1:0] sumt;

  for (genvar j = 0; j < NTR; j++) begin : g_trit
    assign t_live[j] = a[2*j] & w[2*j];
    assign t_neg[j]  = a[2*j+1] ^ w[2*j+1];
  end

  always_comb begin
    npos = '0;
    nneg = '0;
    for (int j = 0; j < NTR; j++) begin
      npos = npos + TCW'(t_live[j] & ~t_neg[j]);
      nneg = nneg + TCW'(t_live[j] &  t_neg[j]);
    end
    sumt = ACC_W'(npos) - ACC_W'(nneg);
  end

  always_comb begin
    unique case (mode)
      MD_INT8: dot = sum8;
      MD_BIN:  dot = sumb;
      MD_TER:  dot = sumt;
      default: dot = '0;
    endcase
  end

  AST_BIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_BIN) |-> (dot[0] == 1'b0) && (dot <= BIN_LIM) && (dot >= -BIN_LIM)); // R4
  AST_TER_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_TER) |-> (dot <= TER_LIM) && (dot >= -TER_LIM)); // R5
  AST_I8_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_INT8) |-> (dot <= I8_LIM) && (dot >= -I8_LIM)); // R3
  AST_RSV_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RSV) |-> (dot == '0)); // R11

endmodule

// File: rtl/mvmac_acc.sv
module mvmac_acc #(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    clr,
  input  logic signed [ACC_W-1:0] dot,
  output logic signed [ACC_W-1:0] acc
);

  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] addend;

  assign base   = clr  ? '0  : acc;
  assign addend = take ? dot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= base + addend; // modular sum gives the wrap
  end

  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !take |=> acc == '0); // R8
  AST_CLR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clr && take |=> acc == $past(dot)); // R9
  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && take |=> acc == ACC_W'($past(acc) + $past(dot))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !take |=> $stable(acc)); // R12

endmodule

// File: rtl/mvmac_top.sv
module mvmac_top
  import mvmac_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int LANE_W = 32,
  parameter int ACC_W  = 32,
  localparam int VEC_W = NUM_CH * LANE_W,
  localparam int OUT_W = NUM_CH * ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_mode,
  input  logic             in_bcast,
  input  logic             acc_clr,
  input  logic [VEC_W-1:0] in_act,
  input  logic [VEC_W-1:0] in_wgt,
  output logic             acc_valid,
  output logic [OUT_W-1:0] acc_vec
);

  mac_mode_e  mode;
  logic       take;
  logic [VEC_W-1:0] act_sel;

  assign mode     = mac_mode_e'(in_mode);
  assign in_ready = 1'b1;
  assign take     = in_valid && (mode != MD_RSV);

  mvmac_route #(
    .NUM_CH (NUM_CH),
    .LANE_W (LANE_W)
  ) i_route (
    .bcast   (in_bcast),
    .act_vec (in_act),
    .act_sel (act_sel)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic signed [ACC_W-1:0] dot_k;
    logic signed [ACC_W-1:0] acc_k;

    mvmac_lane_dot #(
      .LANE_W (LANE_W),
      .ACC_W  (ACC_W)
    ) i_dot (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .a     (act_sel[k*LANE_W +: LANE_W]),
      .w     (in_wgt[k*LANE_W +: LANE_W]),
      .dot   (dot_k)
    );

    mvmac_acc #(
      .ACC_W (ACC_W)
    ) i_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .clr   (acc_clr),
      .dot   (dot_k),
      .acc   (acc_k)
    );

    assign acc_vec[k*ACC_W +: ACC_W] = acc_k;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_valid <= 1'b0;
    else        acc_valid <= in_valid;
  end

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> acc_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !acc_valid); // R2
  AST_RSV_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_mode == 2'b11) && !acc_clr |=> $stable(acc_vec)); // R11

endmodule

// File: tb/test_mvmac_top.sv
module test_mvmac_top;

  localparam int NUM_CH = 32;
  localparam int LANE_W = 32;
  localparam int VEC_W  = NUM_CH * LANE_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [1:0]       in_mode;
  logic             in_bcast;
  logic             acc_clr;
  logic [VEC_W-1:0] in_act;
  logic [VEC_W-1:0] in_wgt;
  logic             acc_valid;
  logic [VEC_W-1:0] acc_vec;

  always #2 clk = ~clk; // 250 MHz

  mvmac_top i_mvmac_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .in_bcast  (in_bcast),
    .acc_clr   (acc_clr),
    .in_act    (in_act),
    .in_wgt    (in_wgt),
    .acc_valid (acc_valid),
    .acc_vec   (acc_vec)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [VEC_W-1:0] exp_q [$];
  string            tag_q [$];
  logic signed [31:0] model [NUM_CH];

  function automatic int trit_val(logic [1:0] t);
    case (t)
      2'b01:   return 1;
      2'b11:   return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int ref_dot(logic [1:0] md, logic [31:0] a, logic [31:0] w);
    int s = 0;
    case (md)
      2'b00: for (int i = 0; i < 4; i++) s += $signed(a[8*i +: 8]) * $signed(w[8*i +: 8]);
      2'b01: for (int i = 0; i < 32; i++) s += (a[i] == w[i]) ? 1 : -1;
      2'b10: for (int j = 0; j < 16; j++) s += trit_val(a[2*j +: 2]) * trit_val(w[2*j +: 2]);
      default: s = 0;
    endcase
    return s;
  endfunction

  function automatic logic [VEC_W-1:0] model_vec();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < NUM_CH; k++) v[32*k +: 32] = model[k];
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < NUM_CH; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic report(string tag, logic [VEC_W-1:0] act_v, logic [VEC_W-1:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_err++;
      for (int k = 0; k < NUM_CH; k++) begin
        if (act_v[32*k +: 32] !== exp_v[32*k +: 32]) begin
          $display("FAIL %s ch%0d actual=%h expected=%h", tag, k,
                   act_v[32*k +: 32], exp_v[32*k +: 32]);
          break;
        end
      end
    end
  endtask

  task automatic chk_bit(string tag, logic act_b, logic exp_b);
    n_chk++;
    if (act_b !== exp_b) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act_b, exp_b);
    end
  endtask

  // driver: called at a falling edge, leaves at the next falling edge
  task automatic beat(logic [1:0] md, logic bc, logic [VEC_W-1:0] a,
                      logic [VEC_W-1:0] w, logic clr_i, string tag);
    for (int k = 0; k < NUM_CH; k++) begin
      logic [31:0] ak;
      ak = bc ? a[31:0] : a[32*k +: 32];
      model[k] = (clr_i ? 32'sd0 : model[k]) + ref_dot(md, ak, w[32*k +: 32]);
    end
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
    in_valid = 1'b1; in_mode = md; in_bcast = bc;
    in_act = a; in_wgt = w; acc_clr = clr_i;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0; acc_clr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each result pulse with the oldest expectation
  always @(negedge clk) begin
    if (rst_n === 1'b1 && acc_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R2 unexpected acc_valid actual=1 expected=0");
      end else begin
        logic [VEC_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        report(t, acc_vec, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [VEC_W-1:0] a;
    logic [VEC_W-1:0] w;
    for (int k = 0; k < NUM_CH; k++) model[k] = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'b00; in_bcast = 1'b0;
    acc_clr = 1'b0; in_act = '0; in_wgt = '0;
    repeat (3) @(negedge clk);
    report("R1 accumulators in reset", acc_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    report("R1 accumulators after reset", acc_vec, '0);
    chk_bit("R1 acc_valid after reset", acc_valid, 1'b0);
    chk_bit("R2 in_ready", in_ready, 1'b1);

    // R9 load with clear, then R3/R7 int8 vector-vector accumulation
    beat(2'b00, 1'b0, rnd_vec(), rnd_vec(), 1'b1, "R9 clear-load int8");
    for (int i = 0; i < 4; i++) beat(2'b00, 1'b0, rnd_vec(), rnd_vec(), 1'b0, "R3 R7 int8 vv");
    a = {NUM_CH*4{8'h80}}; w = {NUM_CH*4{8'h7F}};
    beat(2'b00, 1'b0, a, w, 1'b0, "R3 int8 -128*127");
    idle(2);

    // R4 binary: full agreement, full disagreement, random
    a = rnd_vec();
    beat(2'b01, 1'b0, a, a, 1'b1, "R4 binary all agree");
    beat(2'b01, 1'b0, a, ~a, 1'b0, "R4 binary all differ");
    for (int i = 0; i < 4; i++) beat(2'b01, 1'b0, rnd_vec(), rnd_vec(), 1'b0, "R4 binary random");

    // R5 ternary: every code pair, then random
    a = {NUM_CH{8'b11_10_01_00, 8'b11_10_01_00, 8'b01_01_11_11, 8'b10_00_11_01}};
    w = {NUM_CH{8'b11_11_11_11, 8'b01_01_01_01, 8'b11_01_11_01, 8'b10_10_01_01}};
    beat(2'b10, 1'b0, a, w, 1'b1, "R5 ternary codes");
    for (int i = 0; i < 4; i++) beat(2'b10, 1'b0, rnd_vec(), rnd_vec(), 1'b0, "R5 ternary random");
    idle(1);

    // R6 broadcast with random upper activation entries, all three modes
    for (int md = 0; md < 3; md++) beat(2'(md), 1'b1, rnd_vec(), rnd_vec(), 1'b0, "R6 broadcast");

    // R11 reserved mode adds nothing
    beat(2'b11, 1'b0, rnd_vec(), rnd_vec(), 1'b0, "R11 reserved mode");
    idle(1);

    // R12 hold while idle
    idle(5);
    report("R12 hold while idle", acc_vec, model_vec());

    // R8 clear without a beat
    acc_clr = 1'b1; in_valid = 1'b0;
    for (int k = 0; k < NUM_CH; k++) model[k] = '0;
    @(negedge clk);
    acc_clr = 1'b0;
    report("R8 clear only", acc_vec, '0);
    chk_bit("R8 no result pulse on clear", acc_valid, 1'b0);

    // R2 back-to-back burst of mixed modes
    for (int i = 0; i < 24; i++)
      beat(2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)), rnd_vec(), rnd_vec(), 1'b0,
           "R2 back-to-back burst");
    idle(2);

    // R10 wrap: 32768 beats of +65536 reach 2^31
    a = {NUM_CH*4{8'h80}};
    beat(2'b00, 1'b0, a, a, 1'b1, "R10 wrap preload");
    for (int i = 1; i < 32768; i++) beat(2'b00, 1'b0, a, a, 1'b0, "R10 wrap ramp");
    idle(2);
    report("R10 wrapped value", acc_vec, {NUM_CH{32'h8000_0000}});

    idle(3);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL R2 missing results actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

endmodule